// File: doc/BRIEF.md
# MDIO Management Master with MDC Generator

This block is a clause-22 station-management master. It runs from a 125 MHz system clock and drives a free-running management clock (MDC) to one or more external PHYs. A single configuration input picks the MDC rate. The fast rate divides the system clock by 7, with 3 cycles high and 4 cycles low. The slow rate divides it by 50, with 25 cycles high and 25 cycles low. A change of rate is applied only when MDC next goes from low to high, so no high or low phase is ever cut short.

Software writes a command word to start a transfer. The word holds a start bit, a read/write opcode, the two low bits of the PHY address and a 5-bit register address. Write data comes with it. The block then sends one complete 64-bit management frame, most significant bit first. The frame is a 32-bit preamble of ones, start code 01, the opcode, a 5-bit PHY address whose top three bits are always zero, the register address, a 2-bit turnaround and 16 data bits.

On a read, the master releases the data line from the turnaround onward and collects the 16 bits the PHY returns. The start bit reads back as busy and clears itself when the frame is over. For a read, the returned data is already in the read-data register by then.

Top module: `mdio_master`

## Requirements
- R1: During and after reset MDC is low, busy is 0, the MDIO output enable is 0 and the read data is 0. The rate starts as slow, and MDC toggles continuously from reset release whether or not a transfer is running.
- R2: With the fast rate in force, every MDC high phase lasts exactly 3 system-clock cycles and every low phase lasts exactly 4.
- R3: With the slow rate in force, every MDC high phase and every low phase lasts exactly 25 system-clock cycles.
- R4: A change of the speed input takes effect only at the next MDC rising edge. An MDC high phase and the low phase that follows it always use the same rate (3 then 4, or 25 then 25).
- R5: A command load with busy at 0 sets busy on the next cycle and captures opcode, address and write data at that moment. A load while busy is 1 is ignored, and this includes the cycle in which busy clears.
- R6: The frame is 64 bits, MSB first. Bits 63..32 are all ones and bits 31..30 are 01. Bits 29..28 hold the opcode: 01 for write, 10 for read. Bits 27..25 are 000, bits 24..23 are the programmed PHY address bits, and bits 22..18 are the register address. The first bit is launched on the first MDC fall after busy rises.
- R7: The MDIO output changes only in the cycle in which MDC falls. Read data is sampled in the cycle in which MDC rises.
- R8: On a write, the output enable is high for all 64 bits, the turnaround (bits 17..16) is driven as 10, and bits 15..0 carry the captured write data.
- R9: On a read, the output enable is high for bits 63..18 and low from the first turnaround bit through the last data bit. The 16 bits sampled in the data field form the read data, first-received bit as MSB. The read data is updated while busy is still 1.
- R10: Busy clears on the MDC fall that ends the last data bit. At that point the output enable is 0, and it stays 0 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdLoad | input | 1 | One-cycle strobe: write the command word with its start bit set |
| cmdRead | input | 1 | Opcode of the command: 1 read, 0 write |
| cmdPhyLow | input | 2 | Programmable low bits of the PHY address |
| cmdRegAddr | input | 5 | PHY register address |
| cmdWrData | input | 16 | Data word for a write |
| speedFast | input | 1 | Rate select: 1 divide-by-7, 0 divide-by-50 |
| busy | output | 1 | Start bit read back; clears itself at frame end |
| rdData | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Value driven onto the MDIO line |
| mdioOe | output | 1 | Output enable for the MDIO line |
| mdioIn | input | 1 | Value sensed on the MDIO line |

## Verification
Two pairs of events can land on the same edge. The first pair is a new command load and the self-clearing of the start bit. The bench predicts the closing MDC fall of a fast-rate frame from the preceding rise and holds the load strobe across exactly that edge. It then requires busy to stay 0 and the line to stay released for the next periods. The second pair is a speed change and an MDC rising boundary. The bench flips the rate inside high phases, inside low phases and in the middle of frames. A monitor of phase lengths then requires each high phase and the low phase after it to belong to one rate, and the frame contents must still come out intact.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 5;
  localparam int TA_FIRST   = FRAME_BITS - DATA_BITS - 2;   // bit index of first turnaround bit
  localparam int DATA_FIRST = FRAME_BITS - DATA_BITS;

  // control-to-datapath strobes
  typedef struct packed {
    logic accept;   // capture command fields into the frame register
    logic load;     // launch first frame bit
    logic shift;    // launch next frame bit
    logic letGo;    // release MDIO for read turnaround
    logic sample;   // shift in one read bit
    logic last;     // final read bit: update read data
    logic done;     // frame finished
  } mdioStb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int FAST_HIGH = 3,
  parameter int FAST_LOW  = 4,
  parameter int SLOW_HIGH = 25,
  parameter int SLOW_LOW  = 25
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdLoad,
  input  logic     cmdRead,
  input  logic     speedFast,
  output logic     mdc,
  output logic     busy,
  output mdioStb_t stb
);
  localparam int MAX_A  = (FAST_HIGH > FAST_LOW) ? FAST_HIGH : FAST_LOW;
  localparam int MAX_B  = (SLOW_HIGH > SLOW_LOW) ? SLOW_HIGH : SLOW_LOW;
  localparam int MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_PH + 1);
  localparam int BW     = $clog2(FRAME_BITS);

  logic [CW-1:0] phaseCnt, phaseLen;
  logic          mdcQ, fastSel, term, riseStb, fallStb;
  logic          startQ, activeQ, readQ, lastBit;
  logic [BW-1:0] bitCnt;

  // phase length for the current MDC level and latched rate
  always_comb begin
    if (mdcQ) phaseLen = fastSel ? CW'(FAST_HIGH) : CW'(SLOW_HIGH);
    else      phaseLen = fastSel ? CW'(FAST_LOW)  : CW'(SLOW_LOW);
    term    = (phaseCnt == phaseLen - CW'(1));
    riseStb = term && !mdcQ;
    fallStb = term && mdcQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      mdcQ     <= 1'b0;
      fastSel  <= 1'b0;
    end else if (term) begin
      phaseCnt <= '0;
      mdcQ     <= ~mdcQ;
      if (!mdcQ) fastSel <= speedFast;   // rate switches only at a rising edge
    end else begin
      phaseCnt <= phaseCnt + CW'(1);
    end
  end

  always_comb begin
    lastBit    = (bitCnt == BW'(FRAME_BITS - 1));
    stb        = '0;
    stb.accept = cmdLoad && !startQ;
    stb.load   = fallStb && startQ && !activeQ;
    stb.shift  = fallStb && activeQ && !lastBit;
    stb.done   = fallStb && activeQ && lastBit;
    stb.letGo  = stb.shift && readQ && (bitCnt == BW'(TA_FIRST - 1));
    stb.sample = riseStb && activeQ && readQ && (bitCnt >= BW'(DATA_FIRST));
    stb.last   = stb.sample && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ  <= 1'b0;
      activeQ <= 1'b0;
      readQ   <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (stb.accept) begin
        startQ <= 1'b1;
        readQ  <= cmdRead;
      end
      if (stb.load) begin
        activeQ <= 1'b1;
        bitCnt  <= '0;
      end
      if (stb.shift) bitCnt <= bitCnt + BW'(1);
      if (stb.done) begin
        activeQ <= 1'b0;
        startQ  <= 1'b0;
      end
    end
  end

  assign mdc  = mdcQ;
  assign busy = startQ;
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int PHY_LOW_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStb_t             stb,
  input  logic                 cmdRead,
  input  logic [PHY_LOW_W-1:0] cmdPhyLow,
  input  logic [ADDR_BITS-1:0] cmdRegAddr,
  input  logic [DATA_BITS-1:0] cmdWrData,
  input  logic                 mdioIn,
  output logic                 mdioOut,
  output logic                 mdioOe,
  output logic [DATA_BITS-1:0] rdData
);
  localparam int HI_ZERO = ADDR_BITS - PHY_LOW_W;

  logic [FRAME_BITS-1:0] frameSr, frameNew;
  logic [DATA_BITS-1:0]  rdSr, rdQ;

  always_comb begin
    frameNew = {{PRE_BITS{1'b1}}, 2'b01,
                cmdRead ? 2'b10 : 2'b01,
                {HI_ZERO{1'b0}}, cmdPhyLow, cmdRegAddr,
                cmdRead ? 2'b11 : 2'b10,
                cmdRead ? {DATA_BITS{1'b1}} : cmdWrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '1;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
      rdSr    <= '0;
      rdQ     <= '0;
    end else begin
      if (stb.accept) frameSr <= frameNew;
      if (stb.load || stb.shift) begin
        mdioOut <= frameSr[FRAME_BITS-1];
        frameSr <= {frameSr[FRAME_BITS-2:0], 1'b1};
      end
      if (stb.load) mdioOe <= 1'b1;
      if (stb.letGo) mdioOe <= 1'b0;
      if (stb.done) begin
        mdioOe  <= 1'b0;
        mdioOut <= 1'b1;
      end
      if (stb.sample) rdSr <= {rdSr[DATA_BITS-2:0], mdioIn};
      if (stb.last)   rdQ  <= {rdSr[DATA_BITS-2:0], mdioIn};
    end
  end

  assign rdData = rdQ;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int FAST_HIGH = 3,
  parameter int FAST_LOW  = 4,
  parameter int SLOW_HIGH = 25,
  parameter int SLOW_LOW  = 25,
  parameter int PHY_LOW_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdLoad,
  input  logic                 cmdRead,
  input  logic [PHY_LOW_W-1:0] cmdPhyLow,
  input  logic [4:0]           cmdRegAddr,
  input  logic [15:0]          cmdWrData,
  input  logic                 speedFast,
  output logic                 busy,
  output logic [15:0]          rdData,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic                 mdioOe,
  input  logic                 mdioIn
);
  mdioStb_t stb;

  mdio_ctrl #(
    .FAST_HIGH(FAST_HIGH), .FAST_LOW(FAST_LOW),
    .SLOW_HIGH(SLOW_HIGH), .SLOW_LOW(SLOW_LOW)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdRead(cmdRead),
    .speedFast(speedFast), .mdc(mdc), .busy(busy), .stb(stb)
  );

  mdio_dpath #(.PHY_LOW_W(PHY_LOW_W)) dpathInst (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdRead(cmdRead),
    .cmdPhyLow(cmdPhyLow), .cmdRegAddr(cmdRegAddr), .cmdWrData(cmdWrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int FAST_HIGH = 3,
  parameter int FAST_LOW  = 4,
  parameter int SLOW_HIGH = 25,
  parameter int SLOW_LOW  = 25
) (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic busy
);
  logic [7:0] hiCnt, loCnt, lastHi;
  logic       hiSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt  <= '0;
      loCnt  <= '0;
      lastHi <= '0;
      hiSeen <= 1'b0;
    end else begin
      hiCnt <= mdc ? hiCnt + 8'd1 : 8'd0;
      loCnt <= mdc ? 8'd0 : loCnt + 8'd1;
      if (!mdc && hiCnt != 8'd0) begin
        lastHi <= hiCnt;
        hiSeen <= 1'b1;
      end
    end
  end

  // R2 R3
  mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdc) |-> (hiCnt == 8'(FAST_HIGH) || hiCnt == 8'(SLOW_HIGH)));

  // R2 R3
  mdc_low_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> (loCnt == 8'(FAST_LOW) || loCnt == 8'(SLOW_LOW)));

  // R4
  mdc_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mdc) && hiSeen) |->
      ((lastHi == 8'(FAST_HIGH) && loCnt == 8'(FAST_LOW)) ||
       (lastHi == 8'(SLOW_HIGH) && loCnt == 8'(SLOW_LOW))));

  // R7
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> $fell(mdc));

  // R10
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($fell(mdc) && !mdioOe));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
endmodule

bind mdio_master mdio_master_chk #(
  .FAST_HIGH(FAST_HIGH), .FAST_LOW(FAST_LOW),
  .SLOW_HIGH(SLOW_HIGH), .SLOW_LOW(SLOW_LOW)
) chkInst (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut),
  .mdioOe(mdioOe), .busy(busy)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, cmdLoad, cmdRead, speedFast, mdioIn;
  logic [1:0]  cmdPhyLow;
  logic [4:0]  cmdRegAddr;
  logic [15:0] cmdWrData;
  logic        busy, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;

  int vecs = 0;
  int errs = 0;

  mdio_master dut (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdRead(cmdRead),
    .cmdPhyLow(cmdPhyLow), .cmdRegAddr(cmdRegAddr), .cmdWrData(cmdWrData),
    .speedFast(speedFast), .busy(busy), .rdData(rdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitFall;
    logic p;
    bit   hit;
    p = mdc; hit = 0;
    while (!hit) begin
      @(negedge clk);
      if (p === 1'b1 && mdc === 1'b0) hit = 1;
      p = mdc;
    end
  endtask

  task automatic waitRise;
    logic p;
    bit   hit;
    p = mdc; hit = 0;
    while (!hit) begin
      @(negedge clk);
      if (p === 1'b0 && mdc === 1'b1) hit = 1;
      p = mdc;
    end
  endtask

  // phase-length and output-timing monitor (R2, R3, R4, R7)
  logic prevM, prevOut;
  int   runLen, lastHi;
  bit   haveHi;
  always @(negedge clk) begin
    if (!rstN) begin
      prevM = 1'b0; prevOut = mdioOut; runLen = 0; haveHi = 0;
    end else begin
      if (mdioOut !== prevOut)
        chk(prevM === 1'b1 && mdc === 1'b0, "R7", "mdioOut moved off MDC fall",
            64'(mdc), 64'(0));
      prevOut = mdioOut;
      if (mdc === prevM) runLen++;
      else begin
        if (prevM === 1'b1) begin
          chk(runLen == 3 || runLen == 25, "R2_R3", "high phase length",
              64'(runLen), 64'(3));
          lastHi = runLen; haveHi = 1;
        end else if (haveHi) begin
          chk((lastHi == 3 && runLen == 4) || (lastHi == 25 && runLen == 25),
              "R4", "low phase vs preceding high", 64'(runLen), 64'(lastHi));
        end
        prevM = mdc; runLen = 1;
      end
    end
  end

  task automatic measure(output int hi, output int lo);
    waitRise;
    hi = 0;
    while (mdc) begin hi++; @(negedge clk); end
    lo = 0;
    while (!mdc) begin lo++; @(negedge clk); end
  endtask

  task automatic runFrame(input bit rd, input logic [1:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pat,
                          input int switchAt, input bit poke, input bit collide);
    logic [63:0] expF, expOe, mask, gotF, gotOe;
    int guard;
    expF  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, 3'b000, phy, ra, 2'b10, wd};
    expOe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    mask  = {{46{1'b1}}, 18'b0};
    gotF  = '0; gotOe = '0;
    @(negedge clk);
    cmdRead = rd; cmdPhyLow = phy; cmdRegAddr = ra; cmdWrData = wd; cmdLoad = 1'b1;
    @(negedge clk);
    cmdLoad = 1'b0;
    chk(busy === 1'b1, "R5", "busy after load", 64'(busy), 64'(1));
    // inputs change after capture: frame must keep the captured fields
    cmdRead = ~rd; cmdPhyLow = ~phy; cmdRegAddr = ~ra; cmdWrData = ~wd;
    guard = 0;
    waitFall;
    while (mdioOe !== 1'b1 && guard < 4) begin waitFall; guard++; end
    for (int k = 0; k < 64; k++) begin
      if (k > 0) waitFall;
      gotF[63-k]  = mdioOut;
      gotOe[63-k] = mdioOe;
      mdioIn = (k >= 48) ? pat[63-k] : 1'b1;
      if (k == switchAt) speedFast = ~speedFast;
      if (poke && k == 20) begin
        cmdLoad = 1'b1; @(negedge clk); cmdLoad = 1'b0;
      end
    end
    chk((gotF & mask) == (expF & mask), "R6", "frame header", gotF & mask, expF & mask);
    chk(gotOe == expOe, rd ? "R9" : "R8", "output enable pattern", gotOe, expOe);
    if (!rd) chk(gotF[17:0] == {2'b10, wd}, "R8", "turnaround and data",
                 64'(gotF[17:0]), 64'({2'b10, wd}));
    waitRise;
    chk(busy === 1'b1, "R10", "busy held through last bit", 64'(busy), 64'(1));
    if (rd) chk(rdData == pat, "R9", "read data before busy clears",
                64'(rdData), 64'(pat));
    if (collide) begin
      // fast rate: the closing fall is 3 edges after the rise
      repeat (2) @(negedge clk);
      cmdRead = 1'b0; cmdLoad = 1'b1;
      @(negedge clk);
      cmdLoad = 1'b0;
      chk(mdc === 1'b0 && busy === 1'b0, "R10", "busy clears on closing fall",
          64'({mdc, busy}), 64'(0));
      guard = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (busy !== 1'b0 || mdioOe !== 1'b0) guard++;
      end
      chk(guard == 0, "R5", "load in clearing cycle ignored", 64'(guard), 64'(0));
    end else begin
      waitFall;
      chk(busy === 1'b0 && mdioOe === 1'b0, "R10", "end of frame",
          64'({busy, mdioOe}), 64'(0));
    end
    if (poke) chk(1'b1, "R5", "load while busy ignored (frame intact above)", 0, 0);
    mdioIn = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int hi, lo;
    rstN = 1'b0; cmdLoad = 1'b0; cmdRead = 1'b0; cmdPhyLow = '0;
    cmdRegAddr = '0; cmdWrData = '0; speedFast = 1'b0; mdioIn = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mdc === 1'b0 && busy === 1'b0 && mdioOe === 1'b0 && rdData === 16'h0,
        "R1", "reset state", 64'({mdc, busy, mdioOe, rdData}), 64'(0));
    rstN = 1'b1;
    // R1: slow rate after reset, MDC runs with no command
    measure(hi, lo);
    chk(hi == 25 && lo == 25, "R1", "free-running slow MDC after reset",
        64'({hi[15:0], lo[15:0]}), 64'({16'd25, 16'd25}));
    chk(busy === 1'b0, "R1", "idle busy", 64'(busy), 64'(0));
    // R3 slow duty
    measure(hi, lo);
    chk(hi == 25, "R3", "slow high", 64'(hi), 64'(25));
    chk(lo == 25, "R3", "slow low", 64'(lo), 64'(25));
    // R4: switch to fast inside a slow high phase
    waitRise;
    speedFast = 1'b1;
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    chk(hi == 25 && lo == 25, "R4", "slow phases finish after switch",
        64'({hi[15:0], lo[15:0]}), 64'({16'd25, 16'd25}));
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    chk(hi == 3, "R4", "fast from next rise", 64'(hi), 64'(3));
    // R2 fast duty
    measure(hi, lo);
    chk(hi == 3, "R2", "fast high", 64'(hi), 64'(3));
    chk(lo == 4, "R2", "fast low", 64'(lo), 64'(4));
    // R4: switch to slow inside a fast low phase
    waitFall;
    speedFast = 1'b0;
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    chk(lo == 4 && hi == 25, "R4", "fast low kept, slow from rise",
        64'({lo[15:0], hi[15:0]}), 64'({16'd4, 16'd25}));
    // slow frames
    runFrame(1'b0, 2'd2, 5'd17, 16'hBEEF, 16'h0, -1, 1'b0, 1'b0);
    runFrame(1'b1, 2'd1, 5'd9, 16'h0, 16'hC35A, -1, 1'b1, 1'b0);
    // sweep at fast rate over PHY low bits, register addresses, both opcodes
    speedFast = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 8; r++) begin
        logic [4:0]  ra;
        logic [15:0] wd;
        ra = {r[2:0], p[1:0]};
        wd = 16'hA5C3 ^ 16'(p * 16'h1357) ^ 16'(r * 16'h0F21);
        runFrame(1'b0, p[1:0], ra, wd, 16'h0, -1, r == 3, 1'b0);
        runFrame(1'b1, p[1:0], ~ra, 16'h0, {wd[7:0], ~wd[15:8]}, -1, 1'b0, r == 5);
      end
    end
    // rate flips in the middle of frames
    runFrame(1'b1, 2'd3, 5'd31, 16'h0, 16'h8001, 10, 1'b0, 1'b0);
    runFrame(1'b0, 2'd0, 5'd0, 16'h7FFE, 16'h0, 30, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule